// File: doc/BRIEF.md
# Automatic Package Sleep Controller

This block sits beside a group of processor cores and decides, without any software request, when the whole package may stop all of its clocks. Each core reports whether it is halted. When automatic sleep is enabled and every core reports halted in the same cycle, the block begins counting. If that all-halted condition holds, with no wake event, for a programmable number of consecutive cycles, the block raises a package-wide clock-off request and reports the package as asleep.

The sleep ends on the next clock edge after any of three things happens: a wake event (an interrupt or bus request), any core dropping its halt indication, or the enable being cleared. The block then returns to monitoring. A later entry needs a fresh, complete qualification window. The dwell length is an input, so firmware or a power controller can tune how long a coincidence of halts must last before it counts. The value 0 is treated as 1.

The package state output has three values: 2'b00 means monitoring, 2'b01 means qualifying (an all-halted run is in progress), and 2'b10 means asleep. The clock-off request is high exactly while the state is 2'b10.

Top module: `pkg_auto_sleep`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, clk_off_req is 0 and pkg_state is 2'b00. Reset may be applied at any time, including while asleep.
- R2: While auto_en is 0, the block never requests clock-off and pkg_state stays 2'b00, even when every core is halted.
- R3: With auto_en at 1, wake_evt at 0 and all cores halted, clk_off_req rises on the clock edge that samples the D-th consecutive qualifying cycle. D is dwell_cycles, and a value of 0 is taken as 1.
- R4: If any core is not halted during qualification, the count is discarded: pkg_state returns to 2'b00 on the next edge, and a full new window is needed.
- R5: While a qualifying run is in progress but shorter than D, pkg_state is 2'b01 and clk_off_req is 0.
- R6: While asleep, pkg_state is 2'b10 and clk_off_req is 1. Both hold for as long as all cores stay halted, auto_en stays 1 and no wake event arrives.
- R7: A wake_evt sampled while asleep clears clk_off_req and sets pkg_state to 2'b00 on the next edge.
- R8: A core that leaves halt while the package is asleep clears clk_off_req and sets pkg_state to 2'b00 on the next edge.
- R9: Clearing auto_en while asleep clears clk_off_req and sets pkg_state to 2'b00 on the next edge.
- R10: A wake_evt sampled during qualification discards the count, and pkg_state returns to 2'b00.
- R11: After waking, re-entry requires a new run of D qualifying cycles counted from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_halted | input | NUM_CORES | Per-core halted indication, 1 = halted |
| auto_en | input | 1 | Enables automatic package sleep |
| wake_evt | input | 1 | Interrupt or bus request that forces wake |
| dwell_cycles | input | CNT_W | Consecutive all-halted cycles required before entry (0 is taken as 1) |
| clk_off_req | output | 1 | Package-wide request to gate all clocks |
| pkg_state | output | 2 | 00 monitoring, 01 qualifying, 10 asleep |

## Verification
A stale or wrong dwell count shows at the ports as a clk_off_req edge one or more cycles away from the D-th qualifying sample. The bench therefore samples the state after every single clock and places both the rising edge and the cycle just before it. A state register stuck in sleep shows one edge after any wake cause, because clk_off_req fails to drop. A count that is not cleared on a wake or on a core leaving halt shows as an early re-entry in the next window. The bench checks each of these within one cycle of the event that exposes it.

// File: rtl/auto_sleep_pkg.sv
`timescale 1ns/1ps
package auto_sleep_pkg;
   typedef enum logic [1:0] {
      PS_RUN   = 2'b00,
      PS_QUAL  = 2'b01,
      PS_SLEEP = 2'b10
   } pkg_state_e;
endpackage

// File: rtl/all_halt_detect.sv
`timescale 1ns/1ps
module all_halt_detect #(
   parameter int NUM_CORES   = 4,
   parameter bit TREE_REDUCE = 1'b1
) (
   input  logic [NUM_CORES-1:0] core_halted,
   output logic                 all_halted
);
   localparam int LVL = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 0;
   localparam int PAD = 1 << LVL;

   generate
      if (NUM_CORES < 1) begin : g_bad_cores
         $error("all_halt_detect: NUM_CORES must be at least 1");
      end

      if (TREE_REDUCE) begin : g_tree
         for (genvar lv = 0; lv <= LVL; lv++) begin : g_lvl
            logic [(PAD >> lv)-1:0] v;
            if (lv == 0) begin : g_leaf
               for (genvar i = 0; i < PAD; i++) begin : g_pad
                  if (i < NUM_CORES) begin : g_real
                     assign v[i] = core_halted[i];
                  end else begin : g_fill
                     assign v[i] = 1'b1;
                  end
               end
            end else begin : g_node
               for (genvar j = 0; j < (PAD >> lv); j++) begin : g_and
                  assign v[j] = g_lvl[lv-1].v[2*j] & g_lvl[lv-1].v[2*j+1];
               end
            end
         end
         assign all_halted = g_lvl[LVL].v[0];
      end else begin : g_flat
         assign all_halted = &core_halted;
      end
   endgenerate
endmodule

// File: rtl/dwell_counter.sv
`timescale 1ns/1ps
module dwell_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             advance,
   input  logic [CNT_W-1:0] dwell_cycles,
   output logic             reached
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] streak;
   logic [CNT_W-1:0] target;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("dwell_counter: CNT_W must be at least 1");
      end
   endgenerate

   always_comb begin
      target  = (dwell_cycles == '0) ? ONE : dwell_cycles;
      reached = (streak >= (target - ONE));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         streak <= '0;
      end else if (clear) begin
         streak <= '0;
      end else if (advance && (streak != MAX)) begin
         streak <= streak + ONE;
      end
   end
endmodule

// File: rtl/sleep_seq.sv
`timescale 1ns/1ps
module sleep_seq
   import auto_sleep_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       all_halted,
   input  logic       auto_en,
   input  logic       wake_evt,
   input  logic       reached,
   output logic       cnt_clear,
   output logic       cnt_advance,
   output pkg_state_e state
);
   pkg_state_e state_nx;
   logic       qualify;

   always_comb begin
      qualify     = auto_en & all_halted & ~wake_evt;
      cnt_advance = qualify & (state != PS_SLEEP);
      cnt_clear   = ~qualify | (state == PS_SLEEP);
      state_nx    = state;
      unique case (state)
         PS_RUN, PS_QUAL: begin
            if (!qualify)     state_nx = PS_RUN;
            else if (reached) state_nx = PS_SLEEP;
            else              state_nx = PS_QUAL;
         end
         PS_SLEEP: begin
            if (!qualify)     state_nx = PS_RUN;
         end
         default:             state_nx = PS_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= PS_RUN;
      else        state <= state_nx;
   end
endmodule

// File: rtl/pkg_auto_sleep.sv
`timescale 1ns/1ps
module pkg_auto_sleep
   import auto_sleep_pkg::*;
#(
   parameter int NUM_CORES   = 4,
   parameter int CNT_W       = 8,
   parameter bit TREE_REDUCE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CORES-1:0] core_halted,
   input  logic                 auto_en,
   input  logic                 wake_evt,
   input  logic [CNT_W-1:0]     dwell_cycles,
   output logic                 clk_off_req,
   output logic [1:0]           pkg_state
);
   logic       all_halted;
   logic       reached;
   logic       cnt_clear;
   logic       cnt_advance;
   pkg_state_e state;

   all_halt_detect #(
      .NUM_CORES  (NUM_CORES),
      .TREE_REDUCE(TREE_REDUCE)
   ) halt_i (
      .core_halted(core_halted),
      .all_halted (all_halted)
   );

   dwell_counter #(
      .CNT_W(CNT_W)
   ) cnt_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (cnt_clear),
      .advance     (cnt_advance),
      .dwell_cycles(dwell_cycles),
      .reached     (reached)
   );

   sleep_seq seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .all_halted (all_halted),
      .auto_en    (auto_en),
      .wake_evt   (wake_evt),
      .reached    (reached),
      .cnt_clear  (cnt_clear),
      .cnt_advance(cnt_advance),
      .state      (state)
   );

   assign clk_off_req = (state == PS_SLEEP);
   assign pkg_state   = state;
endmodule

// File: rtl/pkg_auto_sleep_chk.sv
`timescale 1ns/1ps
module pkg_auto_sleep_chk #(
   parameter int NUM_CORES = 4,
   parameter int CNT_W     = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_CORES-1:0] core_halted,
   input logic                 auto_en,
   input logic                 wake_evt,
   input logic [CNT_W-1:0]     dwell_cycles,
   input logic                 clk_off_req,
   input logic [1:0]           pkg_state
);
   logic unused_dwell;
   assign unused_dwell = ^dwell_cycles;

   // R1: a cycle spent in reset leaves the outputs idle
   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (!clk_off_req && pkg_state == 2'b00));

   // R2: nothing sleeps while automatic entry is off
   assert_no_sleep_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |=> (!clk_off_req && pkg_state == 2'b00));

   // R3: entry only follows a qualifying sample
   assert_entry_qualified_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_off_req) |-> $past(auto_en && !wake_evt && (&core_halted)));

   // R5: the qualifying state never gates clocks
   assert_qual_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkg_state == 2'b01) |-> !clk_off_req);

   // R7: a wake event ends sleep one edge later
   assert_wake_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_off_req && wake_evt) |=> (!clk_off_req && pkg_state == 2'b00));

   // R8: a core leaving halt ends sleep one edge later
   assert_core_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_off_req && !(&core_halted)) |=> (!clk_off_req && pkg_state == 2'b00));

   // R9: clearing the enable ends sleep one edge later
   assert_enable_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_off_req && !auto_en) |=> (!clk_off_req && pkg_state == 2'b00));
endmodule

bind pkg_auto_sleep pkg_auto_sleep_chk #(
   .NUM_CORES(NUM_CORES),
   .CNT_W    (CNT_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .core_halted (core_halted),
   .auto_en     (auto_en),
   .wake_evt    (wake_evt),
   .dwell_cycles(dwell_cycles),
   .clk_off_req (clk_off_req),
   .pkg_state   (pkg_state)
);

// File: tb/pkg_auto_sleep_tb_top.sv
`timescale 1ns/1ps
module pkg_auto_sleep_tb_top;
   localparam int N  = 4;
   localparam int CW = 8;
   localparam int NV = 22;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [N-1:0]  core_halted;
   logic          auto_en;
   logic          wake_evt;
   logic [CW-1:0] dwell_cycles;
   logic          clk_off_req;
   logic [1:0]    pkg_state;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   pkg_auto_sleep #(.NUM_CORES(N), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .core_halted(core_halted), .auto_en(auto_en),
      .wake_evt(wake_evt), .dwell_cycles(dwell_cycles),
      .clk_off_req(clk_off_req), .pkg_state(pkg_state)
   );

   // Vector layout: rid[20:17] exp_req[16] exp_state[15:14] dwell[13:6] wake[5] en[4] halted[3:0]
   function automatic logic [20:0] mk(input int rid, input bit req, input logic [1:0] st,
                                      input int dw, input bit wk, input bit en,
                                      input logic [3:0] h);
      return {4'(rid), req, st, 8'(dw), wk, en, h};
   endfunction

   function automatic string rname(input logic [3:0] id);
      case (id)
         4'd1:  return "R1";
         4'd2:  return "R2";
         4'd3:  return "R3";
         4'd4:  return "R4";
         4'd5:  return "R5";
         4'd6:  return "R6";
         4'd7:  return "R7";
         4'd8:  return "R8";
         4'd9:  return "R9";
         4'd10: return "R10";
         default: return "R11";
      endcase
   endfunction

   localparam logic [20:0] VEC [NV] = '{
      mk(4, 0, 2'b00, 3, 0, 1, 4'b0000),
      mk(5, 0, 2'b01, 3, 0, 1, 4'b1111),
      mk(5, 0, 2'b01, 3, 0, 1, 4'b1111),
      mk(3, 1, 2'b10, 3, 0, 1, 4'b1111),
      mk(6, 1, 2'b10, 3, 0, 1, 4'b1111),
      mk(7, 0, 2'b00, 3, 1, 1, 4'b1111),
      mk(11,0, 2'b01, 3, 0, 1, 4'b1111),
      mk(4, 0, 2'b00, 3, 0, 1, 4'b1011),
      mk(4, 0, 2'b01, 3, 0, 1, 4'b1111),
      mk(4, 0, 2'b01, 3, 0, 1, 4'b1111),
      mk(3, 1, 2'b10, 3, 0, 1, 4'b1111),
      mk(8, 0, 2'b00, 3, 0, 1, 4'b0111),
      mk(11,0, 2'b01, 3, 0, 1, 4'b1111),
      mk(11,0, 2'b01, 3, 0, 1, 4'b1111),
      mk(11,1, 2'b10, 3, 0, 1, 4'b1111),
      mk(9, 0, 2'b00, 3, 0, 0, 4'b1111),
      mk(2, 0, 2'b00, 3, 0, 0, 4'b1111),
      mk(2, 0, 2'b00, 3, 0, 0, 4'b1111),
      mk(10,0, 2'b00, 3, 1, 1, 4'b1111),
      mk(10,0, 2'b01, 3, 0, 1, 4'b1111),
      mk(10,0, 2'b00, 3, 1, 1, 4'b1111),
      mk(10,0, 2'b01, 3, 0, 1, 4'b1111)
   };

   task automatic check(input string tag, input logic [2:0] exp);
      checks++;
      if ({clk_off_req, pkg_state} !== exp) begin
         fails++;
         $display("FAIL %s: req/state actual %b/%b expected %b/%b",
                  tag, clk_off_req, pkg_state, exp[2], exp[1:0]);
      end
   endtask

   task automatic apply(input logic [3:0] h, input bit en, input bit wk, input int dw);
      core_halted  = h;
      auto_en      = en;
      wake_evt     = wk;
      dwell_cycles = CW'(dw);
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      apply(4'b1111, 1'b1, 1'b0, 1);
      rst_n = 1'b0;
      repeat (3) tick();
      check("R1 in reset", 3'b000);
      rst_n = 1'b1;
      apply(4'b0000, 1'b1, 1'b0, 3);
      tick();
      check("R1 after release", 3'b000);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][3:0], VEC[i][4], VEC[i][5], int'(VEC[i][13:6]));
         tick();
         check($sformatf("%s vector %0d", rname(VEC[i][20:17]), i), VEC[i][16:14]);
      end

      // R3: dwell of 0 behaves as 1
      apply(4'b0000, 1'b1, 1'b0, 0);
      tick();
      apply(4'b1111, 1'b1, 1'b0, 0);
      tick();
      check("R3 dwell zero", 3'b110);
      apply(4'b1110, 1'b1, 1'b0, 0);
      tick();
      check("R8 exit after dwell zero", 3'b000);

      // R3: long dwell of 20, edge placed exactly
      apply(4'b1111, 1'b1, 1'b0, 20);
      repeat (19) tick();
      check("R3 dwell 20 one short", 3'b001);
      tick();
      check("R3 dwell 20 reached", 3'b110);
      repeat (5) tick();
      check("R6 held asleep", 3'b110);

      // R1: reset while asleep
      rst_n = 1'b0;
      #1;
      check("R1 reset while asleep", 3'b000);
      tick();
      rst_n = 1'b1;
      apply(4'b1111, 1'b1, 1'b0, 2);
      tick();
      check("R11 fresh count after reset", 3'b001);
      tick();
      check("R3 dwell 2 after reset", 3'b110);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule